// File: doc/BRIEF.md
# Single-Cycle Binary Field Squarer

This block squares an element of the binary extension field of degree 163, defined by the trinomial-plus-terms polynomial x^163 + x^7 + x^6 + x^3 + 1, and completes one squaring per clock cycle. A load strobe takes an operand from the input bus and registers its square. A resquare strobe squares the registered value again in place. A chain of k squarings therefore costs k cycles and needs only one load and one read of the output. This is the pattern an exponentiation-based inverter needs.

The polynomial square is formed by spreading the operand's bits, with a zero between every pair of neighbours. Because the degree is odd, the spread vector splits into a low part, which already lies below degree m, and a high part that is scaled by x^(m+1). The high part is folded back with a shift-and-reduce ladder of d+2 stages, where d is the second-highest exponent of the polynomial. Each stage output is gated by one coefficient of x^(m+1) mod F, and the gated stages are summed in an XOR tree. The whole path is combinational. Only the result register holds state.

Top module: `gfsq_unit`

## Requirements
- R1: A synchronous active-high reset clears the result register, so the output reads zero on the cycle after reset. This holds even if a value was loaded before the reset.
- R2: When the load strobe is high at a clock edge, the output after that edge equals the square of the input operand, reduced modulo x^163 + x^7 + x^6 + x^3 + 1. Bit i of every vector is the coefficient of x^i.
- R3: When the resquare strobe is high and the load strobe is low at an edge, the output after that edge equals the square of the output value before that edge.
- R4: When both strobes are high at the same edge, the load takes priority and the output equals the square of the input operand.
- R5: When both strobes are low, the output holds its value and the input operand has no effect.
- R6: One load followed by 162 resquares returns the originally loaded element, because 163 squarings form the identity map on the field.
- R7: The reduction boundary gives exact results. Squaring x^81 gives x^162 with no reduction. Squaring x^82 gives x^8 + x^7 + x^4 + x. Squaring 0 gives 0, and squaring 1 gives 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Square the input operand into the result register |
| resq | input | 1 | Square the result register in place |
| din | input | 163 | Operand, bit i is the coefficient of x^i |
| sq_out | output | 163 | Registered square |

## Verification
The assertions check every cycle that a load registers the square of the operand, including when the load collides with a resquare. They also check that a lone resquare squares the previous output, and that an idle cycle leaves the output unchanged. They compare against a bit-serial multiply that is separate from the spread-and-fold datapath. The bench scenarios cover the following:
- that reset clears a loaded value,
- the behaviour at the reduction boundary for single-term operands,
- a walking-one sweep over all 163 coefficient positions,
- the full 163-step squaring cycle that returns the starting element.

Per-cycle properties cannot express any of these.

// File: rtl/gfsq_pkg.sv
package gfsq_pkg;

    // Field degree and the low terms of the reduction polynomial (x^7+x^6+x^3+1).
    localparam int FIELD_M = 163;
    localparam logic [FIELD_M-1:0] FIELD_TAIL = {{(FIELD_M-8){1'b0}}, 8'b1100_1001};

    // Source of the next result register value.
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_LOAD = 2'd1,
        SRC_RESQ = 2'd2
    } sq_src_e;

    // Load has priority over resquare.
    function automatic sq_src_e pick_src(input logic load, input logic resq);
        if (load)      return SRC_LOAD;
        else if (resq) return SRC_RESQ;
        else           return SRC_HOLD;
    endfunction

    // Multiply by x and reduce: used only by the reference model below.
    function automatic logic [FIELD_M-1:0] ref_mulx(input logic [FIELD_M-1:0] v);
        logic [FIELD_M-1:0] r;
        r = {v[FIELD_M-2:0], 1'b0};
        if (v[FIELD_M-1]) r = r ^ FIELD_TAIL;
        return r;
    endfunction

    // Bit-serial a*a mod F, a structurally different reference for checking.
    function automatic logic [FIELD_M-1:0] ref_square(input logic [FIELD_M-1:0] a);
        logic [FIELD_M-1:0] p;
        p = '0;
        for (int i = FIELD_M - 1; i >= 0; i--) begin
            p = ref_mulx(p);
            if (a[i]) p = p ^ a;
        end
        return p;
    endfunction

endpackage

// File: rtl/gfsq_spread.sv
// Spreads an operand into its polynomial square and splits it at degree M+1.
module gfsq_spread #(
    parameter int M = gfsq_pkg::FIELD_M
) (
    input  logic [M-1:0] a,
    output logic [M-1:0] lo,   // terms of degree 0..M-1 (degree M is always empty)
    output logic [M-3:0] hi    // coefficient j is the term x^(M+1+j)
);
    localparam int HALF = (M + 1) / 2;

    always_comb begin
        lo = '0;
        hi = '0;
        for (int i = 0; i < HALF; i++) begin
            lo[2*i] = a[i];
        end
        for (int i = HALF; i < M; i++) begin
            hi[2*i-(M+1)] = a[i];
        end
    end
endmodule

// File: rtl/gfsq_fold.sv
// Computes x^(M+1) * hi mod F with a shift-and-reduce ladder and gated XOR sum.
module gfsq_fold #(
    parameter int M = gfsq_pkg::FIELD_M,
    parameter logic [M-1:0] TAIL = gfsq_pkg::FIELD_TAIL
) (
    input  logic [M-3:0] hi,
    output logic [M-1:0] folded
);
    function automatic int top_bit(input logic [M-1:0] v);
        int r;
        r = 0;
        for (int i = 0; i < M; i++) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

    localparam int D = top_bit(TAIL);
    localparam int G = D + 2;                               // digit width
    localparam logic [M-1:0] XM1 = {TAIL[M-2:0], 1'b0};     // x^(M+1) mod F

    logic [M-1:0] shifted [G];
    logic [M-1:0] gated   [G];

    assign shifted[0] = {2'b00, hi};

    for (genvar k = 1; k < G; k++) begin : g_ladder
        assign shifted[k] = {shifted[k-1][M-2:0], 1'b0}
                          ^ (shifted[k-1][M-1] ? TAIL : '0);
    end

    for (genvar k = 0; k < G; k++) begin : g_gate
        assign gated[k] = XM1[k] ? shifted[k] : '0;
    end

    always_comb begin
        folded = '0;
        for (int k = 0; k < G; k++) begin
            folded = folded ^ gated[k];
        end
    end
endmodule

// File: rtl/gfsq_square.sv
// Purely combinational field squarer.
module gfsq_square #(
    parameter int M = gfsq_pkg::FIELD_M,
    parameter logic [M-1:0] TAIL = gfsq_pkg::FIELD_TAIL
) (
    input  logic [M-1:0] a,
    output logic [M-1:0] sq
);
    logic [M-1:0] lo_part;
    logic [M-3:0] hi_part;
    logic [M-1:0] folded;

    gfsq_spread #(.M(M)) u_spread (
        .a  (a),
        .lo (lo_part),
        .hi (hi_part)
    );

    gfsq_fold #(.M(M), .TAIL(TAIL)) u_fold (
        .hi     (hi_part),
        .folded (folded)
    );

    assign sq = lo_part ^ folded;
endmodule

// File: rtl/gfsq_unit.sv
// Registered squarer with load and in-place resquare.
module gfsq_unit
    import gfsq_pkg::*;
#(
    parameter int M = FIELD_M,
    parameter logic [M-1:0] TAIL = FIELD_TAIL
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         resq,
    input  logic [M-1:0] din,
    output logic [M-1:0] sq_out
);
    sq_src_e      src;
    logic [M-1:0] operand;
    logic [M-1:0] squared;
    logic [M-1:0] acc_q;

    assign src = pick_src(load, resq);

    always_comb begin
        unique case (src)
            SRC_LOAD: operand = din;
            default:  operand = acc_q;
        endcase
    end

    gfsq_square #(.M(M), .TAIL(TAIL)) u_square (
        .a  (operand),
        .sq (squared)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (src != SRC_HOLD) begin
            acc_q <= squared;
        end
    end

    assign sq_out = acc_q;
endmodule

// File: rtl/gfsq_unit_checker.sv
module gfsq_unit_checker
    import gfsq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               load,
    input logic               resq,
    input logic [FIELD_M-1:0] din,
    input logic [FIELD_M-1:0] sq_out
);
    assert_load_square_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> sq_out == ref_square($past(din)));

    assert_resquare_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && resq) |=> sq_out == ref_square($past(sq_out)));

    assert_load_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (load && resq) |=> sq_out == ref_square($past(din)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!load && !resq) |=> $stable(sq_out));
endmodule

bind gfsq_unit gfsq_unit_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .resq   (resq),
    .din    (din),
    .sq_out (sq_out)
);

// File: tb/gfsq_unit_bench.sv
module gfsq_unit_bench;
    localparam int M = 163;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load = 1'b0;
    logic         resq = 1'b0;
    logic [M-1:0] din = '0;
    logic [M-1:0] sq_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #10 clk = ~clk;   // 50 MHz

    gfsq_unit u_gfsq_unit (
        .clk(clk), .rst(rst), .load(load), .resq(resq), .din(din), .sq_out(sq_out)
    );

    // Independent model: spread, then clear the top terms one by one from the top.
    function automatic logic [M-1:0] model_sq(input logic [M-1:0] a);
        logic [2*M-2:0] w;
        w = '0;
        for (int i = 0; i < M; i++) w[2*i] = a[i];
        for (int j = 2*M-2; j >= M; j--) begin
            if (w[j]) begin
                w[j] = 1'b0;
                w[j-M+7] = ~w[j-M+7];
                w[j-M+6] = ~w[j-M+6];
                w[j-M+3] = ~w[j-M+3];
                w[j-M]   = ~w[j-M];
            end
        end
        return w[M-1:0];
    endfunction

    function automatic logic [M-1:0] one_hot(input int pos);
        logic [M-1:0] v;
        v = '0;
        v[pos] = 1'b1;
        return v;
    endfunction

    task automatic next_word(output logic [M-1:0] v);
        logic [191:0] acc;
        for (int k = 0; k < 3; k++) begin
            seed = seed ^ (seed << 13);
            seed = seed ^ (seed >> 7);
            seed = seed ^ (seed << 17);
            acc[k*64 +: 64] = seed;
        end
        v = acc[M-1:0];
    endtask

    task automatic check(input string tag, input logic [M-1:0] got, input logic [M-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive strobes for one edge; returns at the following falling edge.
    task automatic step(input logic ld, input logic rq, input logic [M-1:0] d);
        load = ld;
        resq = rq;
        din  = d;
        @(negedge clk);
        load = 1'b0;
        resq = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            errors++;
            $display("FAIL R6 watchdog: got %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [M-1:0] v;
        logic [M-1:0] exp;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset clears", sq_out, '0);
        rst = 1'b0;

        // R7: boundary values
        step(1'b1, 1'b0, '0);
        check("R7 zero", sq_out, '0);
        step(1'b1, 1'b0, one_hot(0));
        check("R7 one", sq_out, one_hot(0));
        step(1'b1, 1'b0, one_hot(81));
        check("R7 x81 no reduction", sq_out, one_hot(162));
        step(1'b1, 1'b0, one_hot(82));
        check("R7 x82 fold", sq_out, one_hot(8) | one_hot(7) | one_hot(4) | one_hot(1));

        // R2: walking one over every coefficient
        for (int p = 0; p < M; p++) begin
            step(1'b1, 1'b0, one_hot(p));
            check("R2 walking one", sq_out, model_sq(one_hot(p)));
        end
        // R2: dense patterns
        step(1'b1, 1'b0, '1);
        check("R2 all ones", sq_out, model_sq('1));
        for (int n = 0; n < 40; n++) begin
            next_word(v);
            step(1'b1, 1'b0, v);
            check("R2 random load", sq_out, model_sq(v));
        end

        // R3: resquare chain
        next_word(v);
        step(1'b1, 1'b0, v);
        exp = model_sq(v);
        for (int n = 0; n < 10; n++) begin
            step(1'b0, 1'b1, ~v);
            exp = model_sq(exp);
            check("R3 resquare", sq_out, exp);
        end

        // R4: load and resquare together, load wins
        next_word(v);
        step(1'b1, 1'b1, v);
        check("R4 load priority", sq_out, model_sq(v));

        // R5: idle cycles ignore din
        exp = sq_out;
        for (int n = 0; n < 4; n++) begin
            next_word(v);
            step(1'b0, 1'b0, v);
            check("R5 hold", sq_out, exp);
        end

        // R6: 163 squarings return the original element
        for (int t = 0; t < 3; t++) begin
            next_word(v);
            if (t == 0) v = one_hot(5) | one_hot(160);
            step(1'b1, 1'b0, v);
            for (int n = 0; n < M - 1; n++) step(1'b0, 1'b1, '0);
            check("R6 full cycle", sq_out, v);
        end

        // R1: reset after a load
        next_word(v);
        step(1'b1, 1'b0, v);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset after load", sq_out, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule